// File: doc/BRIEF.md
# Six-Tap Horizontal Luma Half-Sample Filter

This block produces horizontal half-sample luma predictions for a video decoder. It takes a row-wise stream of 8-bit reference samples and passes each group of six horizontally adjacent samples through the symmetric kernel 1, -5, 20, 20, -5, 1. It then adds a rounding offset of 16, shifts the result arithmetically right by five and clamps it to the range 0..255. Both the input and the output use valid/ready handshakes, and back-pressure on the output stalls the input without losing a sample.

A single-cycle start pulse begins a block. At that pulse the block latches a width code and a height code. The block is 4, 8 or 16 pixels wide and 4, 8 or 16 rows high. For every row the caller supplies the width plus five samples, beginning two columns to the left of the first output column. The filtered pixels leave in raster order. One cycle after the last pixel of the block has been handed over, a done pulse marks the end of the block.

Top module: `luma_hfilt6`

## Requirements
- R1: While reset is asserted and right after it, `out_valid_o`, `in_ready_o` and `done_o` are 0.
- R2: Each output pixel equals clamp(((s0 + s5) + 20*(s2 + s3) - 5*(s1 + s4) + 16) >> 5), where s0..s5 are six consecutive input samples of one row and s0 is the oldest. The raw weighted sum stays within -2550..10710.
- R3: A rounded result below zero comes out as 0, and a result above 255 comes out as 255.
- R4: A row consumes exactly width+5 input samples. Output k of a row (k = 0..width-1) uses row samples k..k+5. The first output of a row follows the sixth sample of that row, and no sample of an earlier row enters a window.
- R5: On `start_i`, width code 0/1/2/3 selects 4/8/16/16 pixels and height code 0/1/2/3 selects 4/8/16/16 rows.
- R6: A block delivers exactly width*height output pixels, in raster order.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_pix_o` keeps its value on the next cycle.
- R8: `done_o` is high for exactly one cycle, the cycle right after the handshake of the last pixel. A new start is accepted from that cycle onward.
- R9: A `start_i` pulse while a block is in progress is ignored, and the block's geometry does not change.
- R10: When no block is in progress, `in_ready_o` and `out_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a block when idle |
| width_sel_i | input | 2 | Block width code (0:4, 1:8, 2/3:16) |
| height_sel_i | input | 2 | Block height code (0:4, 1:8, 2/3:16) |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted this cycle when high with valid |
| in_pix_i | input | 8 | Input luma sample |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_pix_o | output | 8 | Filtered output pixel |
| done_o | output | 1 | One-cycle pulse after the last output handshake |

## Verification
Some properties are checked on every clock cycle:
- the raw sum stays inside its bounded range;
- a stalled output is held steady;
- the column counter stays below the row length;
- a stray start leaves the latched geometry unchanged;
- the done pulse lasts one cycle;
- no output is valid while idle.

Other behaviours only show up over whole scenarios. These are the pixel values and their alignment to the window, clamping at both ends, per-row window restart, the pixel count for each width and height code, and when done appears. The bench covers them with a behavioural reference that computes every expected pixel from the samples it drives. It compares each output handshake against that reference under several data patterns and stall patterns.

// File: rtl/hf6_pkg.sv
package hf6_pkg;
    localparam int TAPS      = 6;
    localparam int RND_SHIFT = 5;

    function automatic int tap_coef(input int idx);
        case (idx)
            0, 5:    return 1;
            1, 4:    return -5;
            default: return 20;
        endcase
    endfunction

    function automatic int sel_to_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4;
            2'd1:    return 8;
            default: return 16;
        endcase
    endfunction
endpackage

// File: rtl/hf6_kernel.sv
module hf6_kernel #(
    parameter int PIX_W = 8,
    parameter int SUM_W = 16
) (
    input  logic [hf6_pkg::TAPS*PIX_W-1:0] taps_i,
    output logic signed [SUM_W-1:0]        sum_o,
    output logic [PIX_W-1:0]               pix_o
);
    localparam int TAPS = hf6_pkg::TAPS;
    localparam int SHIFT = hf6_pkg::RND_SHIFT;
    localparam logic signed [SUM_W-1:0] ROUND = SUM_W'(1 << (SHIFT - 1));
    localparam logic signed [SUM_W-1:0] PMAX  = SUM_W'((1 << PIX_W) - 1);

    logic signed [SUM_W-1:0] term [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        localparam int COEF = hf6_pkg::tap_coef(g);
        assign term[g] = SUM_W'(COEF * $signed({1'b0, taps_i[g*PIX_W +: PIX_W]}));
    end

    logic signed [SUM_W-1:0] raw_sum;
    logic signed [SUM_W-1:0] scaled;

    always_comb begin
        raw_sum = '0;
        for (int i = 0; i < TAPS; i++) begin
            raw_sum = raw_sum + term[i];
        end
        scaled = (raw_sum + ROUND) >>> SHIFT;
        if (scaled < 0) begin
            pix_o = '0;
        end else if (scaled > PMAX) begin
            pix_o = '1;
        end else begin
            pix_o = scaled[PIX_W-1:0];
        end
        sum_o = raw_sum;
    end
endmodule

// File: rtl/hf6_ctrl.sv
module hf6_ctrl #(
    parameter int MAX_W = 16,
    parameter int MAX_H = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] wsel_i,
    input  logic [1:0] hsel_i,
    input  logic       accept_i,
    input  logic       drain_last_i,
    output logic       busy_o,
    output logic       feed_o,
    output logic       produce_o,
    output logic       last_o
);
    localparam int TAPS  = hf6_pkg::TAPS;
    localparam int CNT_W = $clog2(MAX_W + TAPS);
    localparam int ROW_W = $clog2(MAX_H + 1);

    typedef struct packed {
        logic             busy;
        logic             in_done;
        logic [CNT_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] row_len;
        logic [ROW_W-1:0] nrows;
    } ctrl_st_t;

    ctrl_st_t c_d, c_q;

    logic col_end, row_end;

    always_comb begin
        col_end = (c_q.col == c_q.row_len - CNT_W'(1));
        row_end = (c_q.row == c_q.nrows - ROW_W'(1));
        c_d = c_q;
        if (!c_q.busy) begin
            if (start_i) begin
                c_d.busy    = 1'b1;
                c_d.in_done = 1'b0;
                c_d.col     = '0;
                c_d.row     = '0;
                c_d.row_len = CNT_W'(hf6_pkg::sel_to_len(wsel_i) + TAPS - 1);
                c_d.nrows   = ROW_W'(hf6_pkg::sel_to_len(hsel_i));
            end
        end else begin
            if (accept_i) begin
                if (col_end) begin
                    c_d.col = '0;
                    if (row_end) begin
                        c_d.in_done = 1'b1;
                    end else begin
                        c_d.row = c_q.row + ROW_W'(1);
                    end
                end else begin
                    c_d.col = c_q.col + CNT_W'(1);
                end
            end
            if (drain_last_i) begin
                c_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o    = c_q.busy;
    assign feed_o    = c_q.busy && !c_q.in_done;
    assign produce_o = (c_q.col >= CNT_W'(TAPS - 1));
    assign last_o    = col_end && row_end;

    AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy |-> (c_q.col < c_q.row_len)); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && start_i) |=> ($stable(c_q.row_len) && $stable(c_q.nrows))); // R9
endmodule

// File: rtl/hf6_datapath.sv
module hf6_datapath #(
    parameter int PIX_W = 8,
    parameter int SUM_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           accept_i,
    input  logic                           produce_i,
    input  logic                           last_i,
    input  logic [PIX_W-1:0]               in_pix_i,
    input  logic                           out_ready_i,
    input  logic signed [SUM_W-1:0]        sum_i,
    input  logic [PIX_W-1:0]               filt_pix_i,
    output logic [hf6_pkg::TAPS*PIX_W-1:0] taps_o,
    output logic                           out_free_o,
    output logic                           out_valid_o,
    output logic [PIX_W-1:0]               out_pix_o,
    output logic                           drain_last_o,
    output logic                           done_o
);
    localparam int TAPS = hf6_pkg::TAPS;
    localparam int HIST = TAPS - 1;
    localparam logic signed [SUM_W-1:0] SUM_MIN = -SUM_W'(10 * ((1 << PIX_W) - 1));
    localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'(42 * ((1 << PIX_W) - 1));

    typedef struct packed {
        logic [HIST-1:0][PIX_W-1:0] win;
        logic                       ov;
        logic [PIX_W-1:0]           pix;
        logic                       last;
        logic                       done;
    } dp_st_t;

    dp_st_t p_d, p_q;

    for (genvar g = 0; g < HIST; g++) begin : g_pack
        assign taps_o[g*PIX_W +: PIX_W] = p_q.win[g];
    end
    assign taps_o[HIST*PIX_W +: PIX_W] = in_pix_i;

    logic handoff;

    always_comb begin
        handoff    = p_q.ov && out_ready_i;
        out_free_o = !p_q.ov || out_ready_i;
        p_d        = p_q;
        p_d.done   = handoff && p_q.last;
        if (accept_i) begin
            for (int i = 0; i < HIST; i++) begin
                p_d.win[i] = taps_o[(i+1)*PIX_W +: PIX_W];
            end
        end
        if (accept_i && produce_i) begin
            p_d.ov   = 1'b1;
            p_d.pix  = filt_pix_i;
            p_d.last = last_i;
        end else if (handoff) begin
            p_d.ov   = 1'b0;
            p_d.last = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign out_valid_o  = p_q.ov;
    assign out_pix_o    = p_q.pix;
    assign drain_last_o = handoff && p_q.last;
    assign done_o       = p_q.done;

    AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && produce_i) |-> (sum_i >= SUM_MIN && sum_i <= SUM_MAX)); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.ov && !out_ready_i) |=> (p_q.ov && $stable(p_q.pix))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.done |=> !p_q.done); // R8
endmodule

// File: rtl/luma_hfilt6.sv
module luma_hfilt6 #(
    parameter int PIX_W = 8,
    parameter int SUM_W = 16,
    parameter int MAX_W = 16,
    parameter int MAX_H = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       width_sel_i,
    input  logic [1:0]       height_sel_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [PIX_W-1:0] in_pix_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [PIX_W-1:0] out_pix_o,
    output logic             done_o
);
    localparam int TAPS = hf6_pkg::TAPS;

    logic busy, feed, produce, last_smp, accept, out_free, drain_last;
    logic [TAPS*PIX_W-1:0]   taps;
    logic signed [SUM_W-1:0] sum;
    logic [PIX_W-1:0]        filt_pix;

    assign in_ready_o = feed && out_free;
    assign accept     = in_valid_i && in_ready_o;

    hf6_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .wsel_i       (width_sel_i),
        .hsel_i       (height_sel_i),
        .accept_i     (accept),
        .drain_last_i (drain_last),
        .busy_o       (busy),
        .feed_o       (feed),
        .produce_o    (produce),
        .last_o       (last_smp)
    );

    hf6_kernel #(.PIX_W(PIX_W), .SUM_W(SUM_W)) kernel_i (
        .taps_i (taps),
        .sum_o  (sum),
        .pix_o  (filt_pix)
    );

    hf6_datapath #(.PIX_W(PIX_W), .SUM_W(SUM_W)) dp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .produce_i    (produce),
        .last_i       (last_smp),
        .in_pix_i     (in_pix_i),
        .out_ready_i  (out_ready_i),
        .sum_i        (sum),
        .filt_pix_i   (filt_pix),
        .taps_o       (taps),
        .out_free_o   (out_free),
        .out_valid_o  (out_valid_o),
        .out_pix_o    (out_pix_o),
        .drain_last_o (drain_last),
        .done_o       (done_o)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid_o && !in_ready_o)); // R10
endmodule

// File: tb/luma_hfilt6_tb_top.sv
module luma_hfilt6_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [1:0] width_sel_i, height_sel_i;
    logic       in_valid_i, in_ready_o;
    logic [7:0] in_pix_i;
    logic       out_valid_o, out_ready_i;
    logic [7:0] out_pix_o;
    logic       done_o;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    luma_hfilt6 dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .width_sel_i(width_sel_i), .height_sel_i(height_sel_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_pix_i(in_pix_i),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_pix_o(out_pix_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int code_len(input int sel);
        return (sel == 0) ? 4 : (sel == 1) ? 8 : 16;
    endfunction

    function automatic int gen(input int mode, input int r, input int c, input int seed);
        if (mode == 0) return ((r * 37 + c * 101 + seed * 13) ^ (c * c * 7 + r * 3)) & 255;
        if (mode == 1) return (((c + r) % 6 == 1) || ((c + r) % 6 == 4)) ? 255 : 0;
        return 100;
    endfunction

    function automatic int ref_pix(input int mode, input int r, input int k, input int seed);
        int cf[6] = '{1, -5, 20, 20, -5, 1};
        int s = 0;
        for (int i = 0; i < 6; i++) s += cf[i] * gen(mode, r, k + i, seed);
        s = (s + 16) >>> 5;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    task automatic run_block(input int wsel, input int hsel, input int mode,
                             input int seed, input bit stall, input bit poke);
        int w = code_len(wsel);
        int h = code_len(hsel);
        int rl = w + 5;
        int n = rl * h;
        int idx = 0;
        int got = 0;
        int cyc = 0;
        bit held = 0;
        int held_pix = 0;
        bit early_done = 0;
        string tag = (mode == 1) ? "R3" : "R2 R4";
        exp_q.delete();
        for (int r = 0; r < h; r++)
            for (int k = 0; k < w; k++) exp_q.push_back(ref_pix(mode, r, k, seed));

        @(negedge clk);
        start_i = 1; width_sel_i = 2'(wsel); height_sel_i = 2'(hsel);
        @(negedge clk);
        start_i = 0;
        while (got < w * h && cyc < 5000) begin
            out_ready_i = stall ? (((cyc * 7 + seed) % 5) != 0) : 1'b1;
            in_valid_i  = (idx < n) && (stall ? ((cyc % 3) != 1) : 1'b1);
            in_pix_i    = 8'(gen(mode, idx / rl, idx % rl, seed));
            if (poke && cyc == 10) begin
                start_i = 1; width_sel_i = 2'(3 - wsel); height_sel_i = 2'(3 - hsel);
            end else begin
                start_i = 0;
            end
            #1;
            if (done_o) early_done = 1;
            if (held) check(out_valid_o && out_pix_o == 8'(held_pix), "R7", int'(out_pix_o), held_pix);
            held = out_valid_o && !out_ready_i;
            held_pix = int'(out_pix_o);
            if (out_valid_o && out_ready_i) begin
                int e = exp_q.pop_front();
                check(int'(out_pix_o) == e, tag, int'(out_pix_o), e);
                got++;
            end
            if (in_valid_i && in_ready_o) idx++;
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        in_valid_i = 0; start_i = 0; out_ready_i = 1;
        #1;
        check(done_o == 1'b1, "R8", int'(done_o), 1);
        check(!early_done, "R8", int'(early_done), 0);
        check(got == w * h, poke ? "R9 R6" : "R5 R6", got, w * h);
        check(idx == n, "R4", idx, n);
        @(negedge clk); #1;
        check(done_o == 1'b0, "R8", int'(done_o), 0);
        check(!in_ready_o && !out_valid_o, "R10", int'(in_ready_o) + int'(out_valid_o), 0);
    endtask

    initial begin
        #3000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; start_i = 0; width_sel_i = 0; height_sel_i = 0;
        in_valid_i = 0; in_pix_i = 0; out_ready_i = 1;
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid_o && !in_ready_o && !done_o, "R1",
              int'(out_valid_o) + int'(in_ready_o) + int'(done_o), 0);
        @(negedge clk);
        rst_n = 1;
        #1;
        check(!out_valid_o && !in_ready_o && !done_o, "R1",
              int'(out_valid_o) + int'(in_ready_o) + int'(done_o), 0);
        run_block(0, 0, 0, 1, 0, 0);
        run_block(1, 1, 1, 2, 1, 0);
        run_block(2, 2, 0, 3, 1, 1);
        run_block(3, 0, 2, 4, 0, 0);
        run_block(0, 3, 1, 5, 0, 0);
        run_block(2, 1, 0, 6, 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule